// File: doc/BRIEF.md
# Fault-Injection Campaign Controller

This block drives a series of upset-injection experiments against a processor-based device under test. Every campaign starts with a reference run that has no injection. That run records the words the device leaves in its output area and the cycle on which it signals completion. Each later run resets the device and releases it. At a chosen cycle the block raises an interrupt request, and the device's interrupt handler corrupts one of its own storage locations. The block then waits for completion and sorts the run into one of three outcome classes.

The injection cycle comes from one of three sources: a fixed value from configuration, a pseudo-random value masked to a programmable range, or an exhaustive sweep that moves the injection one cycle later on each run. A run is tolerated when both the output words and the completion cycle match the reference. It is a result error when any output bit or the completion cycle differs. It is a sequence loss when the device has not signalled completion by the time a programmable watchdog expires. Each class has its own saturating counter. A flag tells the host when the campaign has finished.

Top module: `fi_campaign_ctrl`

## Requirements
- R1: A pulse on `start` while the block is idle or finished clears all three counters and begins a reference run. During the reference run `dut_irq` is never asserted, and the output words and completion cycle read in that run become the reference.
- R2: Run cycle 0 is the first cycle in which `dut_rst_n` is high. In an injected run `dut_irq` first rises in the run cycle equal to the injection offset. For `cfg_mode` 0 or 3 the offset is `cfg_offset`. For `cfg_mode` 1 the offset is a pseudo-random value ANDed with `cfg_rand_mask`. `dut_irq` is only ever high while `dut_rst_n` is high.
- R3: For `cfg_mode` 2 (sweep), injected run number i (counting from 0) uses offset i. The campaign ends after the run whose offset is the reference completion cycle minus 1, or earlier if the run limit is reached.
- R4: `dut_irq` stays high until the cycle after `dut_ack` is sampled high, and for no more than `cfg_irq_max` cycles (at least one cycle).
- R5: The controller reads output words 0 to OUT_WORDS-1 through `mem_addr`/`mem_rdata`. A completed run counts as tolerated when every bit matches the reference and the completion cycle matches. It counts as a result error when any single bit differs. Each finished run increments exactly one counter.
- R6: A completed run whose output words match but whose completion cycle differs from the reference cycle counts as a result error.
- R7: A run with `dut_done` still low in run cycle `cfg_wdog` counts as a sequence loss. `dut_rst_n` is then driven low before the next run. If `dut_done` is high in that same cycle, the completion wins.
- R8: If the reference run times out, the controller adds one sequence loss and ends the campaign at once.
- R9: The campaign ends after `cfg_runs` injected runs. A value of 0 runs only the reference run.
- R10: Each counter is STAT_W bits wide (32 by default) and holds at its all-ones value instead of wrapping.
- R11: After reset, `campaign_done`, `dut_irq` and all counters are 0 and `dut_rst_n` is low. `campaign_done` is high once a campaign ends and stays high until the next `start`.
- R12: `dut_rst_n` is high only while a run executes or its outputs are being read. It is low for at least one cycle between consecutive runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the controller |
| start | input | 1 | Begin a campaign |
| cfg_mode | input | 2 | Offset source: 0/3 fixed, 1 random, 2 sweep |
| cfg_offset | input | CYC_W | Fixed injection offset |
| cfg_rand_mask | input | CYC_W | Mask applied to the random offset |
| cfg_runs | input | RUN_W | Number of injected runs |
| cfg_wdog | input | CYC_W | Watchdog limit in run cycles |
| cfg_irq_max | input | HOLD_W | Longest interrupt hold in cycles |
| dut_rst_n | output | 1 | Active-low reset to the device |
| dut_irq | output | 1 | Interrupt request that starts the injection routine |
| dut_ack | input | 1 | Interrupt acknowledge from the device |
| dut_done | input | 1 | Device reports that its run is complete |
| mem_addr | output | AW | Output-area word address |
| mem_rdata | input | DATA_W | Output-area read data, valid in the same cycle as the address |
| cnt_tol | output | STAT_W | Tolerated run count |
| cnt_res | output | STAT_W | Result error count |
| cnt_loss | output | STAT_W | Sequence loss count |
| campaign_done | output | 1 | Campaign finished |

## Verification
Two pairs of functions can land on the same cycle. The first pair is the device's completion and the watchdog expiry. The bench sets `cfg_wdog` exactly equal to the device model's completion cycle and expects a tolerated run. It then sets `cfg_wdog` one cycle lower and expects the reference run to end the campaign as a single sequence loss. The second pair is the acknowledge and the hold limit, which both end the interrupt. The bench measures how many cycles `dut_irq` stays high with an acknowledge that arrives early and with no acknowledge at all, and it checks the exhaustive sweep against a device model whose response depends on the injection cycle.

// File: rtl/fi_campaign_ctrl.sv
module fi_campaign_ctrl #(
  parameter int DATA_W    = 16,
  parameter int OUT_WORDS = 4,
  parameter int CYC_W     = 16,
  parameter int RUN_W     = 16,
  parameter int HOLD_W    = 8,
  parameter int STAT_W    = 32,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_mode,
  input  logic [CYC_W-1:0]  cfg_offset,
  input  logic [CYC_W-1:0]  cfg_rand_mask,
  input  logic [RUN_W-1:0]  cfg_runs,
  input  logic [CYC_W-1:0]  cfg_wdog,
  input  logic [HOLD_W-1:0] cfg_irq_max,
  output logic              dut_rst_n,
  output logic              dut_irq,
  input  logic              dut_ack,
  input  logic              dut_done,
  output logic [(OUT_WORDS>1?$clog2(OUT_WORDS):1)-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [STAT_W-1:0] cnt_tol,
  output logic [STAT_W-1:0] cnt_res,
  output logic [STAT_W-1:0] cnt_loss,
  output logic              campaign_done
);
  localparam int AW = (OUT_WORDS > 1) ? $clog2(OUT_WORDS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_RST, S_RUN, S_READ, S_DONE} state_t;

  state_t            state;
  logic [CYC_W-1:0]  cyc, fin_cyc, gold_cyc, off;
  logic [DATA_W-1:0] gold [OUT_WORDS];
  logic              golden, irq_q, mism;
  logic [RUN_W-1:0]  inj_idx;
  logic [15:0]       lfsr;
  logic [HOLD_W-1:0] hold_cnt;
  logic [AW-1:0]     addr;

  logic [CYC_W-1:0] off_next, ref_cyc;
  logic [RUN_W-1:0] nxt_idx;
  logic             last_run, timeout, word_bad, run_bad;

  always_comb begin
    case (cfg_mode)
      2'd1:    off_next = CYC_W'(lfsr) & cfg_rand_mask;
      2'd2:    off_next = CYC_W'(inj_idx);
      default: off_next = cfg_offset;
    endcase
  end

  assign ref_cyc  = golden ? fin_cyc : gold_cyc;
  assign nxt_idx  = golden ? '0 : inj_idx + RUN_W'(1);
  assign last_run = (nxt_idx == cfg_runs) ||
                    (cfg_mode == 2'd2 && 32'(nxt_idx) >= 32'(ref_cyc));
  assign timeout  = (cyc == cfg_wdog);
  assign word_bad = !golden && (mem_rdata != gold[addr]);
  assign run_bad  = mism || word_bad || (fin_cyc != gold_cyc);

  assign dut_rst_n     = (state == S_RUN) || (state == S_READ);
  assign dut_irq       = irq_q;
  assign mem_addr      = addr;
  assign campaign_done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  cyc <= '0;  fin_cyc <= '0;  gold_cyc <= '0;  off <= '0;
      golden <= 1'b0;  irq_q <= 1'b0;  mism <= 1'b0;  inj_idx <= '0;
      lfsr <= SEED;  hold_cnt <= '0;  addr <= '0;
      cnt_tol <= '0;  cnt_res <= '0;  cnt_loss <= '0;
      for (int i = 0; i < OUT_WORDS; i++) gold[i] <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) begin
          cnt_tol <= '0;  cnt_res <= '0;  cnt_loss <= '0;
          golden <= 1'b1;  inj_idx <= '0;  state <= S_RST;
        end
        S_RST: begin
          off      <= off_next;
          lfsr     <= {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
          cyc      <= '0;
          hold_cnt <= '0;
          irq_q    <= !golden && (off_next == '0);
          state    <= S_RUN;
        end
        S_RUN: begin
          cyc <= cyc + CYC_W'(1);
          if (irq_q) begin
            hold_cnt <= hold_cnt + HOLD_W'(1);
            if (dut_ack || ({1'b0, hold_cnt} + (HOLD_W+1)'(1) >= {1'b0, cfg_irq_max}))
              irq_q <= 1'b0;
          end else if (!golden && (cyc + CYC_W'(1) == off)) begin
            irq_q <= 1'b1;
            hold_cnt <= '0;
          end
          if (dut_done) begin
            fin_cyc <= cyc;  addr <= '0;  mism <= 1'b0;  irq_q <= 1'b0;
            state <= S_READ;
          end else if (timeout) begin
            irq_q <= 1'b0;
            if (!(&cnt_loss)) cnt_loss <= cnt_loss + STAT_W'(1);
            if (golden || last_run) state <= S_DONE;
            else begin
              inj_idx <= nxt_idx;
              state <= S_RST;
            end
          end
        end
        S_READ: begin
          addr <= addr + AW'(1);
          if (golden) gold[addr] <= mem_rdata;
          else mism <= mism | word_bad;
          if (addr == AW'(OUT_WORDS-1)) begin
            if (golden) begin
              gold_cyc <= fin_cyc;
              golden <= 1'b0;
            end else if (run_bad) begin
              if (!(&cnt_res)) cnt_res <= cnt_res + STAT_W'(1);
            end else begin
              if (!(&cnt_tol)) cnt_tol <= cnt_tol + STAT_W'(1);
            end
            inj_idx <= nxt_idx;
            state <= last_run ? S_DONE : S_RST;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IRQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    dut_irq |-> dut_rst_n); // R2

  AST_IRQ_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    dut_irq |-> (hold_cnt == '0 || hold_cnt < cfg_irq_max)); // R4

  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (dut_irq && dut_ack) |=> !dut_irq); // R4

  AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> $countones({cnt_tol != $past(cnt_tol), cnt_res != $past(cnt_res),
                                  cnt_loss != $past(cnt_loss)}) <= 1); // R5

  AST_LOSS_RESETS_DUT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RUN && !dut_done && timeout) |=> !dut_rst_n); // R7

  AST_TOL_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (&cnt_tol && !start) |=> &cnt_tol); // R10

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (campaign_done && !start) |=> campaign_done); // R11
endmodule

// File: tb/fi_campaign_ctrl_tb.sv
module fi_campaign_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DUR        = 8;
  localparam int SW         = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [15:0] cfg_offset = '0, cfg_rand_mask = '0, cfg_runs = '0, cfg_wdog = 16'd20;
  logic [7:0]  cfg_irq_max = 8'd5;
  logic [15:0] ack_lat = 16'd2;
  logic dut_rst_n, dut_irq, dut_ack, dut_done, campaign_done;
  logic [1:0]  mem_addr;
  logic [15:0] mem_rdata;
  logic [SW-1:0] cnt_tol, cnt_res, cnt_loss;

  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fi_campaign_ctrl #(.STAT_W(SW)) dut_i (
    .clk, .rst_n, .start, .cfg_mode, .cfg_offset, .cfg_rand_mask, .cfg_runs,
    .cfg_wdog, .cfg_irq_max, .dut_rst_n, .dut_irq, .dut_ack, .dut_done,
    .mem_addr, .mem_rdata, .cnt_tol, .cnt_res, .cnt_loss, .campaign_done);

  // Device model: reacts according to the cycle at which the interrupt arrives.
  logic [15:0] m, irq_at;
  logic seen, corrupt, hang, late;
  always @(posedge clk) begin
    if (!dut_rst_n) begin
      m <= '0; seen <= 0; corrupt <= 0; hang <= 0; late <= 0; irq_at <= '0;
    end else begin
      m <= m + 16'd1;
      if (dut_irq && !seen) begin
        seen <= 1; irq_at <= m;
        if (m == 16'd2 || m == 16'd3) corrupt <= 1;
        if (m == 16'd5) hang <= 1;
        if (m == 16'd6) late <= 1;
      end
    end
  end
  assign dut_done  = dut_rst_n && !hang && (m >= (late ? 16'(DUR+1) : 16'(DUR)));
  assign dut_ack   = dut_irq && seen && (m - irq_at == ack_lat);
  assign mem_rdata = (16'h1234 + 16'h1111 * 16'(mem_addr)) ^
                     ((corrupt && mem_addr == 2'd1) ? 16'h0004 : 16'h0000);

  // Monitor of interrupt instants and widths.
  int runs_seen = 0, irq_cnt = 0, irq_bad = 0;
  logic in_rst = 1'b1;
  always @(posedge clk) begin
    in_rst <= !dut_rst_n;
    if (start) begin
      runs_seen <= 0; irq_cnt <= 0; irq_bad <= 0;
    end else begin
      if (!dut_rst_n && !in_rst) runs_seen <= runs_seen + 1;
      if (dut_irq) irq_cnt <= irq_cnt + 1;
      if (dut_irq && !seen) begin
        if (runs_seen == 0) irq_bad <= irq_bad + 1;
        else if (cfg_mode == 2'd2 && int'(m) != runs_seen - 1) irq_bad <= irq_bad + 1;
        else if (cfg_mode == 2'd1 && (m & ~cfg_rand_mask) != 16'd0) irq_bad <= irq_bad + 1;
        else if ((cfg_mode == 2'd0 || cfg_mode == 2'd3) && m != cfg_offset) irq_bad <= irq_bad + 1;
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++; fails++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
        finish_run();
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic campaign(input logic [1:0] md, input logic [15:0] of, input logic [15:0] rn);
    @(negedge clk);
    cfg_mode = md; cfg_offset = of; cfg_runs = rn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4000 && !campaign_done; i++) @(negedge clk);
  endtask

  // mode, offset, runs, tolerated, result, loss
  localparam logic [57:0] VEC [7] = '{
    {2'd0, 16'd0, 16'd3,   8'd3, 8'd0, 8'd0},
    {2'd0, 16'd2, 16'd2,   8'd0, 8'd2, 8'd0},
    {2'd3, 16'd5, 16'd2,   8'd0, 8'd0, 8'd2},
    {2'd0, 16'd6, 16'd1,   8'd0, 8'd1, 8'd0},
    {2'd2, 16'd0, 16'd100, 8'd4, 8'd3, 8'd1},
    {2'd2, 16'd0, 16'd3,   8'd2, 8'd1, 8'd0},
    {2'd0, 16'd7, 16'd0,   8'd0, 8'd0, 8'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset campaign_done", int'(campaign_done), 0);
    check("R11 reset dut_irq", int'(dut_irq), 0);
    check("R12 reset dut_rst_n", int'(dut_rst_n), 0);
    check("R11 reset counters", int'(cnt_tol) + int'(cnt_res) + int'(cnt_loss), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle campaign_done", int'(campaign_done), 0);

    for (int v = 0; v < 7; v++) begin
      campaign(VEC[v][57:56], VEC[v][55:40], VEC[v][39:24]);
      check("R11 done flag", int'(campaign_done), 1);
      check("R5 tolerated count", int'(cnt_tol), int'(VEC[v][23:16]));
      check("R5 R6 result count", int'(cnt_res), int'(VEC[v][15:8]));
      check("R7 loss count", int'(cnt_loss), int'(VEC[v][7:0]));
      check("R1 R2 R3 R9 irq instants", irq_bad, 0);
    end

    @(negedge clk);
    check("R11 done held", int'(campaign_done), 1);

    cfg_rand_mask = 16'd3;
    campaign(2'd1, 16'd0, 16'd6);
    check("R2 random runs classified", int'(cnt_tol) + int'(cnt_res), 6);
    check("R2 random no loss", int'(cnt_loss), 0);
    check("R2 random offsets within mask", irq_bad, 0);

    ack_lat = 16'd2; cfg_irq_max = 8'd5;
    campaign(2'd0, 16'd0, 16'd1);
    check("R4 irq width with early ack", irq_cnt, 3);
    ack_lat = 16'hFFFF; cfg_irq_max = 8'd4;
    campaign(2'd0, 16'd1, 16'd1);
    check("R4 irq width at hold limit", irq_cnt, 4);
    check("R4 tolerated with no ack", int'(cnt_tol), 1);
    ack_lat = 16'd2; cfg_irq_max = 8'd5;

    cfg_wdog = 16'(DUR);
    campaign(2'd0, 16'd0, 16'd1);
    check("R7 completion wins over watchdog tol", int'(cnt_tol), 1);
    check("R7 completion wins over watchdog loss", int'(cnt_loss), 0);
    cfg_wdog = 16'(DUR - 1);
    campaign(2'd0, 16'd0, 16'd5);
    check("R8 reference timeout loss", int'(cnt_loss), 1);
    check("R8 reference timeout no tol", int'(cnt_tol), 0);
    check("R8 campaign ends", int'(campaign_done), 1);
    cfg_wdog = 16'd20;

    campaign(2'd0, 16'd0, 16'd20);
    check("R10 tolerated saturates", int'(cnt_tol), 15);

    finish_run();
  end
endmodule